// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block issues a single SD/MMC command on the bidirectional CMD line. It can also collect the card's reply. Software-side logic sets up the command in two steps. It first writes a 6-bit command index through one strobe and a 32-bit argument through another. It then pulses `run`, together with three per-command flags: expect a reply, expect a long (136-bit) reply, and do not report CRC mismatches. The engine builds the 48-bit command frame with its CRC7 and shifts it out MSB first. It then listens for the reply start bit, deserializes a 48-bit or 136-bit reply, and stores the payload in four 32-bit response words.

Only clock cycles on which `bus_tick` is high count as card-bus clocks. `bus_tick` comes from a clock divider outside this block. A busy flag covers the whole transaction. After a stop-transmission command (index 12), busy also covers eight extra bus clocks. Three sticky status bits report the reply result: no reply in time, reply CRC mismatch, and malformed reply.

Top module: `sdmmc_cmd_engine`

## Requirements
- R1: `idx_wr` and `arg_wr` load the index and argument registers. A `run` pulse while idle captures those registers and the three run flags, and `busy` is 1 from the next clock edge.
- R2: A `run` pulse while `busy` is 1 has no effect. The transaction timing, the flags and the stored words are unchanged.
- R3: The frame is sent MSB first, one bit per bus tick, with `cmd_oe` high. Its layout is start 0, transmission 1, index[5:0], argument[31:0], CRC7 (polynomial x^7+x^3+1, register cleared to 0, over the first 40 bits), end 1. While not sending, `cmd_out` is 1 and `cmd_oe` is 0.
- R4: Without the expect-reply flag, `busy` falls at the clock edge of the 48th bus tick after acceptance (the tail of R9 comes on top).
- R5: After the end bit, the engine samples CMD on each bus tick. The first 0 within 64 ticks starts the reply, and a 0 on the 64th tick still counts. Otherwise `resp_timeout` is set at the 64th tick and the transaction ends.
- R6: A short reply is 48 bits. Its bits 39..8 (bit 47 being the start bit) go to `resp_word0`, and words 1 to 3 keep their values. `resp_crc_err` is set if the CRC7 over bits 47..8 differs from bits 7..1, unless the ignore-CRC flag was given with `run`.
- R7: A long reply is 136 bits. The 128 bits after the 8-bit header are stored with `resp_word3` most significant and `resp_word0` least significant, so the end bit lands in bit 0 of `resp_word0`. No CRC check is made.
- R8: `resp_err` is set if the received transmission bit is 1 or the end bit is 0. For a long reply it is also set if the six reserved header bits are not all 1.
- R9: When the captured index is 12, `busy` stays high for 8 more bus ticks after the frame, reply or timeout ends.
- R10: Reset clears `busy`, the status bits and the response words. An accepted `run` clears the three status bits. Otherwise the status bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tick | input | 1 | One-cycle enable marking a card-bus clock |
| idx_wr | input | 1 | Write strobe for the command index register |
| idx_wdata | input | 6 | Command index |
| arg_wr | input | 1 | Write strobe for the argument register |
| arg_wdata | input | 32 | Command argument |
| run | input | 1 | Start pulse, accepted only while idle |
| run_get_resp | input | 1 | Reply expected (sampled with run) |
| run_long_resp | input | 1 | Reply is 136 bits (sampled with run) |
| run_ignore_crc | input | 1 | Suppress reply CRC error (sampled with run) |
| cmd_in | input | 1 | CMD line as seen from the card |
| cmd_out | output | 1 | CMD line value driven by the engine |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Transaction in progress |
| resp_timeout | output | 1 | No reply start bit within the window |
| resp_crc_err | output | 1 | Short reply CRC mismatch |
| resp_err | output | 1 | Malformed reply framing |
| resp_word0 | output | 32 | Response word 0 (least significant) |
| resp_word1 | output | 32 | Response word 1 |
| resp_word2 | output | 32 | Response word 2 |
| resp_word3 | output | 32 | Response word 3 (most significant of a long reply) |

## Verification
`busy` rises at the edge after `run` is sampled. It falls at the edge of the last counted tick. That tick count is 48 for the frame, plus the idle ticks and the reply length (or 64 on timeout), plus 8 for index 12. The status bits and words change at the edge of the last reply tick. A bench model counts those ticks from the `bus_tick` it drives itself, predicts `busy` for the next edge, and compares on every falling edge. The frame bits are collected on the falling edge before each tick edge. The words and flags are checked only once `busy` has fallen.

// File: rtl/sdmmc_cmd_pkg.sv
// Shared constants, state type and CRC7 helper for the SD/MMC command engine.
// Assumes the standard 48-bit command frame and 136-bit long reply sizes.
package sdmmc_cmd_pkg;

    localparam int CMD_IDX_W  = 6;
    localparam int CMD_ARG_W  = 32;
    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int WORD_W     = 32;
    localparam int WORD_CNT   = 4;
    localparam int CRC_SPAN   = 40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_TAIL
    } eng_state_t;

    // CRC7 (x^7 + x^3 + 1) over CRC_SPAN bits, MSB first, register cleared to zero.
    function automatic logic [6:0] crc7_span(input logic [CRC_SPAN-1:0] bits);
        logic [6:0] acc;
        logic       fb;
        acc = 7'd0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            fb  = bits[i] ^ acc[6];
            acc = {acc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return acc;
    endfunction

endpackage

// File: rtl/sdmmc_cmd_tx.sv
// Command frame serializer: loads a whole frame, then presents its MSB and
// shifts left on each shift strobe. Assumes the caller issues exactly
// FRAME_BITS shift strobes per load and watches last_bit to stop.
module sdmmc_cmd_tx #(
    parameter int FRAME_BITS = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic [FRAME_BITS-1:0] frame_in,
    output logic                  bit_out,
    output logic                  last_bit
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sr;
    logic [CW-1:0]         cnt;

    // Shift register and bit counter: reload on load, advance on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '1;
            cnt <= '0;
        end else if (load) begin
            sr  <= frame_in;
            cnt <= '0;
        end else if (shift) begin
            sr  <= {sr[FRAME_BITS-2:0], 1'b1};
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_out  = sr[FRAME_BITS-1];
    assign last_bit = (cnt == LAST_IDX);

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sr));

endmodule

// File: rtl/sdmmc_cmd_rx.sv
// Reply deserializer: shifts in one CMD bit per sample strobe, counts bits,
// and flags the final bit of a short or long reply. frame_now shows the
// frame including the bit being sampled, for use on the final sample.
// Assumes clear precedes each reply and the start bit is the first sample.
module sdmmc_cmd_rx #(
    parameter int SHORT_BITS = 48,
    parameter int LONG_BITS  = 136
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 sample,
    input  logic                 long_mode,
    input  logic                 bit_in,
    output logic                 last_bit,
    output logic [LONG_BITS-1:0] frame_now
);
    localparam int CW = $clog2(LONG_BITS + 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT_BITS - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(LONG_BITS - 1);
    localparam logic [CW-1:0] MAX_CNT    = CW'(LONG_BITS);

    logic [LONG_BITS-1:0] sr;
    logic [CW-1:0]        cnt;

    // Capture register and received-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (clear) begin
            sr  <= '0;
            cnt <= '0;
        end else if (sample) begin
            sr  <= frame_now;
            cnt <= cnt + 1'b1;
        end
    end

    assign frame_now = {sr[LONG_BITS-2:0], bit_in};
    assign last_bit  = (cnt == (long_mode ? LAST_LONG : LAST_SHORT));

    p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_CNT);

endmodule

// File: rtl/sdmmc_tick_timer.sv
// Bus-tick counter used for the reply window and the post-stop tail.
// Assumes the controller clears it on every state change.
module sdmmc_tick_timer #(
    parameter int MAX_COUNT = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         step,
    output logic [$clog2(MAX_COUNT+1)-1:0] count
);
    // Counts steps since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (step)   count <= count + 1'b1;
    end

endmodule

// File: rtl/sdmmc_cmd_engine.sv
// SD/MMC command engine top: holds index/argument registers, sequences
// send -> wait for reply -> receive -> optional stop tail, and keeps the
// sticky reply status and the four response words.
// Assumes bus_tick is a one-cycle enable from an external divider and the
// CMD line pad/pull-up logic lives outside this block.
module sdmmc_cmd_engine
    import sdmmc_cmd_pkg::*;
#(
    parameter int RESP_WAIT_TICKS = 64,
    parameter int STOP_TAIL_TICKS = 8,
    parameter int STOP_CMD_IDX    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_tick,
    input  logic                 idx_wr,
    input  logic [CMD_IDX_W-1:0] idx_wdata,
    input  logic                 arg_wr,
    input  logic [CMD_ARG_W-1:0] arg_wdata,
    input  logic                 run,
    input  logic                 run_get_resp,
    input  logic                 run_long_resp,
    input  logic                 run_ignore_crc,
    input  logic                 cmd_in,
    output logic                 cmd_out,
    output logic                 cmd_oe,
    output logic                 busy,
    output logic                 resp_timeout,
    output logic                 resp_crc_err,
    output logic                 resp_err,
    output logic [WORD_W-1:0]    resp_word0,
    output logic [WORD_W-1:0]    resp_word1,
    output logic [WORD_W-1:0]    resp_word2,
    output logic [WORD_W-1:0]    resp_word3
);
    localparam int TMR_MAX = (RESP_WAIT_TICKS > STOP_TAIL_TICKS) ? RESP_WAIT_TICKS : STOP_TAIL_TICKS;
    localparam int TW      = $clog2(TMR_MAX + 1);
    localparam logic [TW-1:0] WAIT_LAST = TW'(RESP_WAIT_TICKS - 1);
    localparam logic [TW-1:0] TAIL_LAST = TW'(STOP_TAIL_TICKS - 1);
    localparam logic [CMD_IDX_W-1:0] STOP_IDX = CMD_IDX_W'(STOP_CMD_IDX);

    eng_state_t            state, state_nxt, post_state;
    logic [CMD_IDX_W-1:0]  idx_q;
    logic [CMD_ARG_W-1:0]  arg_q;
    logic                  get_q, long_q, ign_q, stop_q;
    logic                  accept;
    logic                  tx_bit, tx_last, rx_last;
    logic [LONG_BITS-1:0]  fin;
    logic [TW-1:0]         tmr;
    logic                  wait_expired, tail_done, finish_rx, rx_sample;
    logic [CRC_SPAN-1:0]   tx_head;
    logic [FRAME_BITS-1:0] tx_frame;
    logic                  crc_bad, frame_bad;
    logic [WORD_CNT-1:0][WORD_W-1:0] words_q;

    assign accept       = run && (state == ST_IDLE);
    assign wait_expired = (tmr == WAIT_LAST);
    assign tail_done    = (tmr == TAIL_LAST);
    assign finish_rx    = (state == ST_RECV) && bus_tick && rx_last;
    assign rx_sample    = bus_tick && (((state == ST_WAIT) && !cmd_in) || (state == ST_RECV));
    assign tx_head      = {1'b0, 1'b1, idx_q, arg_q};
    assign tx_frame     = {tx_head, crc7_span(tx_head), 1'b1};
    assign post_state   = stop_q ? ST_TAIL : ST_IDLE;

    // Index and argument registers, written independently at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            arg_q <= '0;
        end else begin
            if (idx_wr) idx_q <= idx_wdata;
            if (arg_wr) arg_q <= arg_wdata;
        end
    end

    // Next-state selection for the transaction sequencer.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (run) state_nxt = ST_SEND;
            ST_SEND: if (bus_tick && tx_last)
                         state_nxt = get_q ? ST_WAIT : post_state;
            ST_WAIT: if (bus_tick) begin
                         if (!cmd_in)          state_nxt = ST_RECV;
                         else if (wait_expired) state_nxt = post_state;
                     end
            ST_RECV: if (bus_tick && rx_last) state_nxt = post_state;
            ST_TAIL: if (bus_tick && tail_done) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    sdmmc_cmd_tx #(.FRAME_BITS(FRAME_BITS)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    ((state == ST_SEND) && bus_tick),
        .frame_in (tx_frame),
        .bit_out  (tx_bit),
        .last_bit (tx_last)
    );

    sdmmc_cmd_rx #(.SHORT_BITS(FRAME_BITS), .LONG_BITS(LONG_BITS)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample    (rx_sample),
        .long_mode (long_q),
        .bit_in    (cmd_in),
        .last_bit  (rx_last),
        .frame_now (fin)
    );

    sdmmc_tick_timer #(.MAX_COUNT(TMR_MAX)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_nxt != state),
        .step  (bus_tick),
        .count (tmr)
    );

    // Reply checks evaluated on the final reply bit.
    always_comb begin
        crc_bad = (crc7_span(fin[FRAME_BITS-1:8]) != fin[7:1]);
        if (long_q)
            frame_bad = fin[LONG_BITS-1] | fin[LONG_BITS-2] | ~(&fin[LONG_BITS-3:LONG_BITS-8]) | ~fin[0];
        else
            frame_bad = fin[FRAME_BITS-1] | fin[FRAME_BITS-2] | ~fin[0];
    end

    // Per-command flags and sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            get_q <= 1'b0; long_q <= 1'b0; ign_q <= 1'b0; stop_q <= 1'b0;
            resp_timeout <= 1'b0; resp_crc_err <= 1'b0; resp_err <= 1'b0;
        end else if (accept) begin
            get_q  <= run_get_resp;
            long_q <= run_long_resp;
            ign_q  <= run_ignore_crc;
            stop_q <= (idx_q == STOP_IDX);
            resp_timeout <= 1'b0; resp_crc_err <= 1'b0; resp_err <= 1'b0;
        end else begin
            if ((state == ST_WAIT) && bus_tick && cmd_in && wait_expired)
                resp_timeout <= 1'b1;
            if (finish_rx) begin
                resp_crc_err <= !long_q && !ign_q && crc_bad;
                resp_err     <= frame_bad;
            end
        end
    end

    // Response word capture: all words for a long reply, word 0 for a short one.
    for (genvar w = 0; w < WORD_CNT; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_q[w] <= '0;
            else if (finish_rx) begin
                if (long_q)
                    words_q[w] <= fin[w*WORD_W +: WORD_W];
                else if (w == 0)
                    words_q[w] <= fin[FRAME_BITS-9 -: WORD_W];
            end
        end
    end

    assign resp_word0 = words_q[0];
    assign resp_word1 = words_q[1];
    assign resp_word2 = words_q[2];
    assign resp_word3 = words_q[3];
    assign busy       = (state != ST_IDLE);
    assign cmd_oe     = (state == ST_SEND);
    assign cmd_out    = cmd_oe ? tx_bit : 1'b1;

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run) |=> busy);
    p_run_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run) |=> $stable({get_q, long_q, ign_q, stop_q}));
    p_line_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);
    p_timeout_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_timeout |-> (!resp_crc_err && !resp_err));
    p_crc_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_crc_err |-> (!ign_q && !long_q));
    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !run) |=> $stable({resp_timeout, resp_crc_err, resp_err}));

endmodule

// File: tb/test_sdmmc_cmd_engine.sv
module test_sdmmc_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b0;
    logic        idx_wr = 1'b0;
    logic [5:0]  idx_wdata = '0;
    logic        arg_wr = 1'b0;
    logic [31:0] arg_wdata = '0;
    logic        run = 1'b0, run_get_resp = 1'b0, run_long_resp = 1'b0, run_ignore_crc = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, busy, resp_timeout, resp_crc_err, resp_err;
    logic [31:0] resp_word0, resp_word1, resp_word2, resp_word3;

    always #5 clk = ~clk;

    sdmmc_cmd_engine i_sdmmc_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .run(run), .run_get_resp(run_get_resp), .run_long_resp(run_long_resp),
        .run_ignore_crc(run_ignore_crc), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .busy(busy), .resp_timeout(resp_timeout), .resp_crc_err(resp_crc_err), .resp_err(resp_err),
        .resp_word0(resp_word0), .resp_word1(resp_word1), .resp_word2(resp_word2), .resp_word3(resp_word3)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int tick_div = 0;
    bit rsp_q[$];
    bit txq[$];
    bit model_busy = 1'b0;
    int model_rem = 0;
    int pending_total = 0;

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [39:0] v);
        logic [6:0] c = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            logic top = c[6];
            c = {c[5:0], 1'b0};
            if (v[i] != top) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_short(input logic trans, input logic [5:0] idx,
                                              input logic [31:0] pl, input bit bad_crc);
        logic [39:0] h = {1'b0, trans, idx, pl};
        logic [6:0]  c = ref_crc(h);
        if (bad_crc) c = c ^ 7'h01;
        return {h, c, 1'b1};
    endfunction

    task automatic push_bits(input logic [135:0] v, input int n, input int delay);
        for (int i = 0; i < delay; i++) rsp_q.push_back(1'b1);
        for (int i = n - 1; i >= 0; i--) rsp_q.push_back(v[i]);
    endtask

    // Reference model: bus tick source, card model, busy prediction, frame capture.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            checks++;
            if (busy !== model_busy) begin
                fails++;
                $display("FAIL R4 busy timing (R1 R9) cycle %0d: actual=%0b expected=%0b", cyc, busy, model_busy);
            end
        end
        tick_div = (tick_div + 1) % 3;
        bus_tick = (tick_div == 0);
        if (cmd_oe && bus_tick) txq.push_back(cmd_out);
        if (model_busy && bus_tick) begin
            model_rem--;
            if (model_rem == 0) model_busy = 1'b0;
        end else if (!model_busy && run && rst_n) begin
            model_busy = 1'b1;
            model_rem  = pending_total;
        end
        if (busy && !cmd_oe && bus_tick)
            cmd_in = (rsp_q.size() > 0) ? rsp_q.pop_front() : 1'b1;
        else if (!busy)
            cmd_in = 1'b1;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit get,
                           input bit lng, input bit ign, input int total, input int poke);
        logic [39:0] h;
        logic [47:0] exp_f, act_f;
        @(posedge clk); #2 idx_wr = 1'b1; idx_wdata = idx;
        @(posedge clk); #2 idx_wr = 1'b0; arg_wr = 1'b1; arg_wdata = arg;
        @(posedge clk); #2 arg_wr = 1'b0; run = 1'b1;
        run_get_resp = get; run_long_resp = lng; run_ignore_crc = ign;
        pending_total = total; txq.delete();
        @(posedge clk); #2 run = 1'b0;
        if (poke > 0) begin
            // R2: a second run with different flags while busy must be ignored.
            repeat (poke) @(posedge clk);
            #2 run = 1'b1; run_get_resp = 1'b0; run_long_resp = 1'b0; run_ignore_crc = 1'b1;
            @(posedge clk); #2 run = 1'b0;
        end
        while (model_busy || busy) @(posedge clk);
        repeat (3) @(posedge clk);
        h = {2'b01, idx, arg};
        exp_f = {h, ref_crc(h), 1'b1};
        act_f = '0;
        for (int i = 0; i < txq.size() && i < 48; i++) act_f[47 - i] = txq[i];
        chk("R3", "frame bit count", 128'(txq.size()), 128'd48);
        chk("R3", "frame bits", 128'(act_f), 128'(exp_f));
    endtask

    task automatic chk_status(input string req, input bit to, input bit ce, input bit re);
        #1;
        chk(req, "resp_timeout", 128'(resp_timeout), 128'(to));
        chk(req, "resp_crc_err", 128'(resp_crc_err), 128'(ce));
        chk(req, "resp_err",     128'(resp_err),     128'(re));
    endtask

    initial begin
        logic [127:0] lp;
        logic [31:0]  w0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R10 / R3: reset state
        chk("R10", "busy after reset", 128'(busy), 128'd0);
        chk("R10", "words after reset", {resp_word3, resp_word2, resp_word1, resp_word0}, 128'd0);
        chk_status("R10", 0, 0, 0);
        chk("R3", "idle line", 128'({cmd_oe, cmd_out}), 128'b01);

        // R4: no-reply command
        run_cmd(6'd0, 32'h0, 0, 0, 0, 48, 0);
        chk_status("R4", 0, 0, 0);

        // R7: long reply after 5 idle ticks, payload CRC field deliberately wrong
        lp = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
        push_bits({2'b00, 6'h3F, lp}, 136, 5);
        run_cmd(6'd2, 32'h0, 1, 1, 0, 48 + 5 + 136, 0);
        chk("R7", "long words", {resp_word3, resp_word2, resp_word1, resp_word0}, lp);
        chk_status("R7", 0, 0, 0);

        // R6: short reply keeps words 1..3
        push_bits(136'(mk_short(1'b0, 6'd8, 32'h0000_01AA, 0)), 48, 2);
        run_cmd(6'd8, 32'h0000_01AA, 1, 0, 0, 48 + 2 + 48, 0);
        chk("R6", "short word0", 128'(resp_word0), 128'h0000_01AA);
        chk("R6", "words1-3 kept", {resp_word3, resp_word2, resp_word1}, lp[127:32]);
        chk_status("R6", 0, 0, 0);

        // R6: bad CRC reported
        push_bits(136'(mk_short(1'b0, 6'd13, 32'hCAFE_F00D, 1)), 48, 0);
        run_cmd(6'd13, 32'h1234_0000, 1, 0, 0, 48 + 0 + 48, 0);
        chk_status("R6", 0, 1, 0);
        chk("R6", "word0 bad crc", 128'(resp_word0), 128'hCAFE_F00D);

        // R6 / R10: bad CRC ignored; accepted run clears previous crc flag
        push_bits(136'(mk_short(1'b0, 6'd13, 32'h5555_AAAA, 1)), 48, 3);
        run_cmd(6'd13, 32'h1234_0000, 1, 0, 1, 48 + 3 + 48, 0);
        chk_status("R6", 0, 0, 0);

        // R8: transmission bit 1
        push_bits(136'(mk_short(1'b1, 6'd7, 32'h0F0F_0F0F, 0)), 48, 1);
        run_cmd(6'd7, 32'hFFFF_0000, 1, 0, 0, 48 + 1 + 48, 0);
        chk_status("R8", 0, 0, 1);

        // R5: timeout, words untouched
        w0 = resp_word0;
        run_cmd(6'd55, 32'h0, 1, 0, 0, 48 + 64, 0);
        chk_status("R5", 1, 0, 0);
        chk("R5", "word0 after timeout", 128'(resp_word0), 128'(w0));
        repeat (20) @(posedge clk);
        chk_status("R10", 1, 0, 0);

        // R5: start bit on the 64th tick still found
        push_bits(136'(mk_short(1'b0, 6'd3, 32'hA5A5_5A5A, 0)), 48, 63);
        run_cmd(6'd3, 32'h0, 1, 0, 0, 48 + 63 + 48, 0);
        chk_status("R5", 0, 0, 0);
        chk("R5", "late reply word0", 128'(resp_word0), 128'hA5A5_5A5A);

        // R9: stop command with reply, then without
        push_bits(136'(mk_short(1'b0, 6'd12, 32'h0000_0900, 0)), 48, 1);
        run_cmd(6'd12, 32'h0, 1, 0, 0, 48 + 1 + 48 + 8, 0);
        chk_status("R9", 0, 0, 0);
        run_cmd(6'd12, 32'hDEAD_BEEF, 0, 0, 0, 48 + 8, 0);
        chk_status("R9", 0, 0, 0);

        // R2: run pulse in the middle of a long transaction
        lp = 128'hFFFF_0000_1357_9BDF_2468_ACE0_8000_0001;
        push_bits({2'b00, 6'h3F, lp}, 136, 4);
        run_cmd(6'd9, 32'h0001_0000, 1, 1, 0, 48 + 4 + 136, 200);
        chk("R2", "words after ignored run", {resp_word3, resp_word2, resp_word1, resp_word0}, lp);
        chk_status("R2", 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule